// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns parallel characters into an asynchronous serial stream. A character written to a one-entry holding register is moved into the shift register when the shifter is free. While that character is being sent, the next one can already be written. The shifter reads the holding register again as soon as the last stop bit of the current frame ends, so consecutive frames follow each other without an idle gap.

Each frame has a low start bit, then 7 or 8 data bits sent least significant bit first, then an optional parity bit, then one or two high stop bits. A 3-bit format code chooses the frame layout from a fixed set of eight entries. The transmit clock is an input sampled in the system clock domain. Each falling edge of it is one tick. A bit lasts 1, 16 or 64 ticks. A control code can force the line to a continuous low break level. The `tx_empty` flag tells the producer when the holding register can take another character.

Top module: `serial_tx_dbuf`

## Requirements
- R1: After `rst_n` is released, `txd` is 1 and `tx_empty` is 1.
- R2: A frame is sent as one start bit of value 0, then the data bits with bit 0 first, then the parity bit if the format has one, then one or two stop bits of value 1.
- R3: `word_sel` sets the format (data bits / parity / stop bits) as follows: 000=7/even/2, 001=7/odd/2, 010=7/even/1, 011=7/odd/1, 100=8/none/2, 101=8/none/1, 110=8/even/1, 111=8/odd/1.
- R4: With even parity, the data bits plus the parity bit hold an even number of ones. With odd parity, they hold an odd number of ones.
- R5: When the shifter is idle and a character is waiting, the start bit appears on `txd` at the next tick.
- R6: A write (`wr_en`=1) clears `tx_empty` at the following clock edge. Moving the character into the shifter sets `tx_empty` again.
- R7: A character written while a frame is being sent has its start bit at the first tick after the last stop bit of that frame, with no idle bit between the two frames.
- R8: A tick is a 1-to-0 change of `txclk`, sampled on `clk`. `txd` changes only at a tick. `div_sel` 00, 01 and 10 give a bit period of 1, 16 and 64 ticks.
- R9: With `tx_ctl`=11, `txd` goes to 0 at the next tick and stays at 0.
- R10: A change of `word_sel` during a frame applies to the bits that follow it, including where the frame ends.
- R11: While `div_sel`=11, the transmitter is held in reset from the next clock edge: `txd`=1, `tx_empty`=1, a character being sent is dropped, and writes are ignored.
- R12: When there is nothing to send, `txd` stays at 1 (mark level).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txclk | input | 1 | Transmit bit clock; each falling edge is one tick |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| div_sel | input | 2 | Bit period select: 00=1, 01=16, 10=64 ticks; 11 holds the transmitter in reset |
| word_sel | input | 3 | Frame format code |
| tx_ctl | input | 2 | 11 forces a break (low) on the line |
| txd | output | 1 | Serial output |
| tx_empty | output | 1 | Holding register can take a character |

## Verification
All eight format codes are swept with several data values at a one-tick bit period. The expected frames are built bit by bit in the bench, so any error in bit order, parity sense or stop-bit count shows up. Pairs of characters at the 16- and 64-tick periods separate a correct prescaler and back-to-back reload from designs that insert an idle gap or miscount ticks. A format change in the middle of a frame, a break request on an idle line and a hold-in-reset during a frame each check behaviour that a plain frame sweep does not reach.

// File: rtl/serial_tx_dbuf.sv
module serial_tx_dbuf #(
  parameter int DIV_MID  = 16,
  parameter int DIV_SLOW = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       txclk,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic [1:0] div_sel,
  input  logic [2:0] word_sel,
  input  logic [1:0] tx_ctl,
  output logic       txd,
  output logic       tx_empty
);
  localparam int PW = $clog2(DIV_SLOW);

  logic          txclk_q, busy, hold_full, txd_q;
  logic [7:0]    hold_q, sh_q;
  logic [3:0]    idx;
  logic [PW-1:0] pcnt;

  wire mrst = (div_sel == 2'b11);
  wire tick = txclk_q & ~txclk;

  wire [PW-1:0] per_m1 = (div_sel == 2'b00) ? '0 :
                         (div_sel == 2'b01) ? PW'(DIV_MID - 1) : PW'(DIV_SLOW - 1);
  wire bit_end = tick & (pcnt == per_m1);

  wire       nd8      = word_sel[2];
  wire       par_en   = ~(word_sel[2] & ~word_sel[1]);
  wire       two_stop = (word_sel[2:1] == 2'b00) | (word_sel == 3'b100);
  wire [3:0] ndw      = nd8 ? 4'd8 : 4'd7;
  wire [3:0] last_idx = ndw + {3'b000, par_en} + (two_stop ? 4'd2 : 4'd1);

  logic          load, busy_n, hold_full_n, line_bit, par_bit;
  logic [3:0]    idx_n;
  logic [PW-1:0] pcnt_n;
  logic [7:0]    sh_n;

  always_comb begin
    load   = busy ? (bit_end & (idx >= last_idx) & hold_full) : (tick & hold_full);
    busy_n = busy;
    idx_n  = idx;
    pcnt_n = pcnt;
    sh_n   = sh_q;
    if (load) begin
      busy_n = 1'b1;
      idx_n  = '0;
      pcnt_n = '0;
      sh_n   = hold_q;
    end else if (busy && bit_end) begin
      pcnt_n = '0;
      if (idx >= last_idx) busy_n = 1'b0;
      else                 idx_n  = idx + 4'd1;
    end else if (busy && tick) begin
      pcnt_n = pcnt + 1'b1;
    end
    hold_full_n = wr_en | (hold_full & ~load);
  end

  always_comb begin
    par_bit = (nd8 ? ^sh_n : ^sh_n[6:0]) ^ word_sel[0];
    if (idx_n == 4'd0)                        line_bit = 1'b0;
    else if (idx_n <= ndw)                    line_bit = sh_n[3'(idx_n - 4'd1)];
    else if (par_en && idx_n == ndw + 4'd1)   line_bit = par_bit;
    else                                      line_bit = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) txclk_q <= 1'b0;
    else        txclk_q <= txclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; hold_full <= 1'b0; txd_q <= 1'b1;
      hold_q <= '0; sh_q <= '0; idx <= '0; pcnt <= '0;
    end else if (mrst) begin
      busy <= 1'b0; hold_full <= 1'b0; txd_q <= 1'b1;
      idx <= '0; pcnt <= '0;
    end else begin
      busy      <= busy_n;
      hold_full <= hold_full_n;
      idx       <= idx_n;
      pcnt      <= pcnt_n;
      sh_q      <= sh_n;
      if (wr_en) hold_q <= wr_data;
      if (tick)  txd_q  <= (tx_ctl == 2'b11) ? 1'b0 : (busy_n ? line_bit : 1'b1);
    end
  end

  assign txd      = txd_q;
  assign tx_empty = ~hold_full;
endmodule

// File: rtl/serial_tx_dbuf_chk.sv
module serial_tx_dbuf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       txclk,
  input logic       wr_en,
  input logic [1:0] div_sel,
  input logic [1:0] tx_ctl,
  input logic       txd,
  input logic       tx_empty
);
  logic clk_prev;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) clk_prev <= 1'b0;
    else        clk_prev <= txclk;
  wire fall = clk_prev & ~txclk;

  p_txd_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall && div_sel != 2'b11) |=> $stable(txd));
  p_write_fills_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && div_sel != 2'b11) |=> !tx_empty);
  p_hold_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (div_sel == 2'b11) |=> (txd && tx_empty));
  p_break_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && tx_ctl == 2'b11 && div_sel != 2'b11) |=> !txd);
endmodule

bind serial_tx_dbuf serial_tx_dbuf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txclk(txclk), .wr_en(wr_en), .div_sel(div_sel),
  .tx_ctl(tx_ctl), .txd(txd), .tx_empty(tx_empty)
);

// File: tb/serial_tx_dbuf_tb.sv
`timescale 1ns/1ps
module serial_tx_dbuf_tb;
  logic clk = 1'b0, rst_n = 1'b0, txclk = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] div_sel = 2'b00, tx_ctl = 2'b00;
  logic [2:0] word_sel = 3'b101;
  logic txd, tx_empty;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  serial_tx_dbuf u_dut (
    .clk(clk), .rst_n(rst_n), .txclk(txclk), .wr_en(wr_en), .wr_data(wr_data),
    .div_sel(div_sel), .word_sel(word_sel), .tx_ctl(tx_ctl), .txd(txd), .tx_empty(tx_empty)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) txclk = 1'b1;
    @(negedge clk) txclk = 1'b0;
    @(negedge clk);
  endtask

  task automatic write(input logic [7:0] v);
    @(negedge clk) begin wr_en = 1'b1; wr_data = v; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  function automatic int build(input logic [7:0] d, input logic [2:0] ws, output logic [15:0] f);
    int nd, np, ns, ones; bit odd;
    case (ws)
      3'd0: begin nd = 7; np = 1; odd = 0; ns = 2; end
      3'd1: begin nd = 7; np = 1; odd = 1; ns = 2; end
      3'd2: begin nd = 7; np = 1; odd = 0; ns = 1; end
      3'd3: begin nd = 7; np = 1; odd = 1; ns = 1; end
      3'd4: begin nd = 8; np = 0; odd = 0; ns = 2; end
      3'd5: begin nd = 8; np = 0; odd = 0; ns = 1; end
      3'd6: begin nd = 8; np = 1; odd = 0; ns = 1; end
      default: begin nd = 8; np = 1; odd = 1; ns = 1; end
    endcase
    f = '1; f[0] = 1'b0; ones = 0;
    for (int i = 0; i < nd; i++) begin f[1+i] = d[i]; ones += d[i]; end
    if (np == 1) f[1+nd] = ((ones % 2) == 1) ^ odd;
    return 1 + nd + np + ns;
  endfunction

  task automatic run(input logic [7:0] a, input logic [7:0] b, input bit two,
                     input logic [2:0] ws, input logic [1:0] ds);
    logic [15:0] fa, fb; int la, lb, p, total, bad, fa_t, fa_a, fa_e; logic e;
    string tag;
    p = (ds == 2'b00) ? 1 : (ds == 2'b01) ? 16 : 64;
    @(negedge clk) begin word_sel = ws; div_sel = ds; end
    la = build(a, ws, fa); lb = build(b, ws, fb);
    total = la + (two ? lb : 0);
    write(a);
    check(tx_empty == 1'b0, "R6 empty cleared by write", tx_empty, 0);
    bad = 0; fa_t = 0; fa_a = 0; fa_e = 0;
    for (int t = 0; t < total * p; t++) begin
      do_tick();
      if (t == 0) begin
        check(txd == 1'b0, "R5 start at first tick", txd, 0);
        check(tx_empty == 1'b1, "R6 empty set on transfer", tx_empty, 1);
        if (two) begin
          write(b);
          check(tx_empty == 1'b0, "R6 empty cleared while busy", tx_empty, 0);
        end
      end
      e = (t / p < la) ? fa[t/p] : fb[t/p - la];
      if (txd !== e) begin
        if (bad == 0) begin fa_t = t; fa_a = txd; fa_e = e; end
        bad++;
      end
    end
    tag = two ? "R7 back-to-back frames" : (ds != 2'b00) ? "R8 bit period" : "R2 R3 R4 frame";
    check(bad == 0, $sformatf("%s ws=%0d d=%02h tick %0d", tag, ws, a, fa_t), fa_a, fa_e);
    do_tick();
    check(txd == 1'b1, "R12 idle mark after frame", txd, 1);
    check(tx_empty == 1'b1, "R12 empty when idle", tx_empty, 1);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(txd == 1'b1, "R1 reset txd", txd, 1);
    check(tx_empty == 1'b1, "R1 reset empty", tx_empty, 1);

    for (int ws = 0; ws < 8; ws++)
      for (int k = 0; k < 8; k++)
        run(8'((k * 53 + ws * 29 + 1) ^ (k << 5)), 8'h00, 1'b0, 3'(ws), 2'b00);
    run(8'hFF, 8'h00, 1'b0, 3'd1, 2'b00);
    run(8'h00, 8'h00, 1'b0, 3'd7, 2'b00);

    run(8'h5A, 8'hC3, 1'b1, 3'd6, 2'b00);
    run(8'h81, 8'h7E, 1'b1, 3'd7, 2'b01);
    run(8'h4B, 8'h12, 1'b1, 3'd0, 2'b10);
    run(8'hA7, 8'h00, 1'b0, 3'd3, 2'b10);

    // R10: 8N2 switched to 8N1 before the stop bits
    @(negedge clk) begin word_sel = 3'b100; div_sel = 2'b00; end
    write(8'hA5);
    do_tick();
    check(txd == 1'b0, "R10 start bit", txd, 0);
    write(8'h3C);
    for (int i = 0; i < 8; i++) begin
      do_tick();
      check(txd == ((8'hA5 >> i) & 1), "R10 data bit", txd, (8'hA5 >> i) & 1);
    end
    @(negedge clk) word_sel = 3'b101;
    do_tick();
    check(txd == 1'b1, "R10 single stop", txd, 1);
    do_tick();
    check(txd == 1'b0, "R10 next start after one stop", txd, 0);
    for (int i = 0; i < 9; i++) do_tick();
    do_tick();
    check(txd == 1'b1, "R10 idle after second frame", txd, 1);

    // R9 and R8: break only at a tick
    @(negedge clk) tx_ctl = 2'b11;
    @(negedge clk);
    check(txd == 1'b1, "R8 no change without tick", txd, 1);
    do_tick();
    check(txd == 1'b0, "R9 break low", txd, 0);
    do_tick();
    check(txd == 1'b0, "R9 break held", txd, 0);
    @(negedge clk) tx_ctl = 2'b00;
    do_tick();
    check(txd == 1'b1, "R9 break released", txd, 1);

    // R11: hold in reset during a frame
    @(negedge clk) begin word_sel = 3'b101; div_sel = 2'b01; end
    write(8'h00);
    write(8'h00);
    do_tick();
    check(txd == 1'b0, "R11 frame running", txd, 0);
    @(negedge clk) div_sel = 2'b11;
    @(negedge clk);
    check(txd == 1'b1, "R11 line released", txd, 1);
    check(tx_empty == 1'b1, "R11 holding cleared", tx_empty, 1);
    write(8'h00);
    check(tx_empty == 1'b1, "R11 write ignored", tx_empty, 1);
    @(negedge clk) div_sel = 2'b00;
    for (int i = 0; i < 4; i++) begin
      do_tick();
      check(txd == 1'b1, "R11 nothing sent after release", txd, 1);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule